// File: doc/BRIEF.md
# Host Adapter Command Register Interface

This block is the device side of a byte-wide register window that a host reaches over a small I/O bus with a two-bit offset. Writes go either to a control register, which carries reset and interrupt-clear strobes, or to a command/parameter port. Reads return a status byte, a data-in byte or an interrupt byte. The host issues a command one byte at a time. It writes an opcode and then the fixed number of parameter bytes that the opcode takes. It then reads the fixed number of reply bytes, and the block raises a command-complete interrupt. Every step is paced by the flags in the status byte.

The sequencer has six named states. DIAG is the diagnostic period after a hard reset. IDLE means ready for an opcode. PARAM waits for the next parameter byte. LATCH holds busy while a parameter byte is absorbed. REPLY presents a reply byte. FETCH is the one-cycle gap while the next reply byte is loaded. The transitions are: DIAG to IDLE when the diagnostic count ends. IDLE to PARAM when an opcode with parameters is accepted. IDLE to REPLY when an opcode with only a reply is accepted. PARAM to LATCH on every parameter byte. LATCH to PARAM when more parameters remain. LATCH to REPLY when the parameters are done and a reply follows. LATCH to IDLE when the command completes with no reply. REPLY to FETCH on a read while more bytes remain. FETCH to REPLY always. REPLY to IDLE on the read of the last byte. A hard reset sends any state to DIAG, and a soft reset sends any state to IDLE.

The mailbox-start opcode takes a separate path. It needs no parameters and is accepted even while a reply is pending. It pulses a strobe for a mailbox engine and never raises command complete. Nothing in the block drives a SCSI bus or performs DMA.

Top module: `hba_cmd_regs`

## Requirements
- R1: Offset 0 reads status and writes control. Offset 1 reads data-in and writes command/parameter. Offset 2 reads the interrupt byte. Offset 3 reads 0x00. Writes to offsets 2 and 3 change nothing.
- R2: After rst_n or a control write with bit 7 set, status reads 0xA0 (diagnostic active 0x80 plus initialisation required 0x20) for exactly DIAG_CYCLES cycles and then exactly 0x30. The interrupt byte reads 0x00.
- R3: Interrupt byte layout: bit 2 (0x04) is command complete, bit 3 (0x08) is SCSI reset state, bits 0 and 1 read 0, and bit 7 (0x80) is set exactly when any of the other bits is set.
- R4: A control write with bit 5 (0x20) clears every interrupt bit and the command-invalid status bit (0x01) in the same cycle. A control write with bit 4 (0x10) sets SCSI reset state, and this takes precedence over a clear in the same write.
- R5: A control write with bit 6 (0x40) abandons any command, clears all interrupt bits, and leaves status at 0x30 on the next cycle, with no diagnostic period.
- R6: Parameter/reply counts: 0x01 takes 4 parameter bytes. 0x81 takes 5. 0x96 takes 1. 0x8D takes 1, and that byte is the reply length. 0x04 replies with 4 bytes. 0x0B replies with 3 bytes.
- R7: After each accepted parameter byte, busy (status 0x08) reads high for exactly BUSY_CYCLES cycles. Offset-1 writes made while busy is high are ignored.
- R8: Ready (status 0x10) drops in the cycle after an opcode of R6 is written. It returns after the last reply byte is read, or after the last parameter has been latched when there is no reply. At that point command complete is set.
- R9: Data-in ready (status 0x04) clears on each data-in read and is set again one cycle later when another byte follows.
- R10: Reply bytes: 0x04 returns 0x40+i for byte i. 0x0B returns 0x00, 0x20, then ADAPTER_ID. 0x8D returns 0x45 for byte 0 and i for byte i > 0.
- R11: Opcode 0x02 is accepted in IDLE and REPLY. It pulses mbox_start for one cycle, leaves the state, status and interrupt byte unchanged, and never sets command complete. During DIAG it is ignored.
- R12: Any opcode not named in R6 or R11, written in IDLE, sets command invalid (status 0x01) and command complete (0x84 in the interrupt byte). Ready stays high and the next command works normally.
- R13: Initialisation required (status 0x20) is set by every reset and cleared when an 0x01 or 0x81 command completes.
- R14: Offset-1 writes other than 0x02 during DIAG, REPLY or FETCH are ignored and do not disturb the reply sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, behaves as a hard reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_rd | input | 1 | Read strobe for one cycle (only offset 1 has a side effect) |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current offset, combinational |
| mbox_start | output | 1 | One-cycle strobe to the mailbox engine |

## Verification
The hardest situation to reach from the ports is a second offset-1 write that lands inside the LATCH window. The host can only produce it by writing on the cycle right after a parameter byte, before any status poll would show busy. The bench issues such a back-to-back write to the reply-length opcode and then checks that the reply length is still the first value. It also counts busy cycles sample by sample. A near-exhaustive sweep covers all 256 opcodes. Every unknown code must produce the invalid response, and every known code must walk through its full parameter and reply sequence.

// File: rtl/hba_regs_pkg.sv
package hba_regs_pkg;

    typedef enum logic [2:0] {
        ST_DIAG,
        ST_IDLE,
        ST_PARAM,
        ST_LATCH,
        ST_FETCH,
        ST_REPLY
    } seq_state_t;

    localparam logic [7:0] OP_MBX_INIT   = 8'h01;
    localparam logic [7:0] OP_MBX_START  = 8'h02;
    localparam logic [7:0] OP_INQUIRY    = 8'h04;
    localparam logic [7:0] OP_CONFIG     = 8'h0B;
    localparam logic [7:0] OP_EXT_MBX    = 8'h81;
    localparam logic [7:0] OP_SETUP_INFO = 8'h8D;
    localparam logic [7:0] OP_WIDE       = 8'h96;

    localparam int CTL_SCSI   = 4;
    localparam int CTL_INTCLR = 5;
    localparam int CTL_SOFT   = 6;
    localparam int CTL_HARD   = 7;

    typedef struct packed {
        logic       known;
        logic [2:0] n_param;
        logic [7:0] n_reply;
        logic       reply_from_param;
        logic       clears_inreq;
    } op_info_t;

    function automatic op_info_t op_lookup(input logic [7:0] op);
        op_info_t r;
        r = '0;
        case (op)
            OP_MBX_INIT: begin
                r.known = 1'b1; r.n_param = 3'd4; r.clears_inreq = 1'b1;
            end
            OP_EXT_MBX: begin
                r.known = 1'b1; r.n_param = 3'd5; r.clears_inreq = 1'b1;
            end
            OP_INQUIRY: begin
                r.known = 1'b1; r.n_reply = 8'd4;
            end
            OP_CONFIG: begin
                r.known = 1'b1; r.n_reply = 8'd3;
            end
            OP_SETUP_INFO: begin
                r.known = 1'b1; r.n_param = 3'd1; r.reply_from_param = 1'b1;
            end
            OP_WIDE: begin
                r.known = 1'b1; r.n_param = 3'd1;
            end
            default: r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/hba_reply_gen.sv
module hba_reply_gen
    import hba_regs_pkg::*;
#(
    parameter int ADAPTER_ID = 7
) (
    input  logic [7:0] op,
    input  logic [7:0] idx,
    output logic [7:0] reply_byte
);
    localparam logic [7:0] ID_BYTE = {5'b0, 3'(ADAPTER_ID)};

    always_comb begin
        reply_byte = 8'h00;
        case (op)
            OP_INQUIRY:    reply_byte = 8'h40 + idx;
            OP_CONFIG: begin
                case (idx)
                    8'd0:    reply_byte = 8'h00;
                    8'd1:    reply_byte = 8'h20;
                    default: reply_byte = ID_BYTE;
                endcase
            end
            OP_SETUP_INFO: reply_byte = (idx == 8'd0) ? 8'h45 : idx;
            default:       reply_byte = 8'h00;
        endcase
    end
endmodule

// File: rtl/hba_cmd_seq.sv
module hba_cmd_seq
    import hba_regs_pkg::*;
#(
    parameter int DIAG_CYCLES = 16,
    parameter int BUSY_CYCLES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hard_rst,
    input  logic       soft_rst,
    input  logic       cmd_wr,
    input  logic [7:0] cmd_byte,
    input  logic       data_rd,
    output seq_state_t st,
    output logic [7:0] op,
    output logic [7:0] rep_idx,
    output logic       mbox_start,
    output logic       evt_done,
    output logic       evt_bad,
    output logic       evt_inreq_clr
);
    localparam int MAX_WAIT = (DIAG_CYCLES > BUSY_CYCLES) ? DIAG_CYCLES : BUSY_CYCLES;
    localparam int CNT_W    = $clog2(MAX_WAIT + 1);
    localparam logic [CNT_W-1:0] DIAG_LOAD = CNT_W'(DIAG_CYCLES - 1);
    localparam logic [CNT_W-1:0] BUSY_LOAD = CNT_W'(BUSY_CYCLES - 1);

    seq_state_t       st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [7:0]       op_q, op_d;
    logic [2:0]       par_left_q, par_left_d;
    logic [7:0]       rep_len_q, rep_len_d;
    logic [7:0]       idx_q, idx_d;
    logic             mbx_q, mbx_d;
    op_info_t         new_info, cur_info;

    assign new_info = op_lookup(cmd_byte);
    assign cur_info = op_lookup(op_q);

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= ST_DIAG;
            cnt_q      <= DIAG_LOAD;
            op_q       <= 8'h00;
            par_left_q <= 3'd0;
            rep_len_q  <= 8'd0;
            idx_q      <= 8'd0;
            mbx_q      <= 1'b0;
        end else begin
            st_q       <= st_d;
            cnt_q      <= cnt_d;
            op_q       <= op_d;
            par_left_q <= par_left_d;
            rep_len_q  <= rep_len_d;
            idx_q      <= idx_d;
            mbx_q      <= mbx_d;
        end
    end

    // next-state and event process
    always_comb begin
        st_d          = st_q;
        cnt_d         = cnt_q;
        op_d          = op_q;
        par_left_d    = par_left_q;
        rep_len_d     = rep_len_q;
        idx_d         = idx_q;
        mbx_d         = 1'b0;
        evt_done      = 1'b0;
        evt_bad       = 1'b0;
        evt_inreq_clr = 1'b0;
        if (hard_rst) begin
            st_d  = ST_DIAG;
            cnt_d = DIAG_LOAD;
        end else if (soft_rst) begin
            st_d = ST_IDLE;
        end else begin
            unique case (st_q)
                ST_DIAG: begin
                    if (cnt_q == '0) st_d = ST_IDLE;
                    else             cnt_d = cnt_q - 1'b1;
                end
                ST_IDLE: begin
                    if (cmd_wr) begin
                        if (cmd_byte == OP_MBX_START) begin
                            mbx_d = 1'b1;
                        end else if (new_info.known) begin
                            op_d       = cmd_byte;
                            par_left_d = new_info.n_param;
                            rep_len_d  = new_info.n_reply;
                            idx_d      = 8'd0;
                            if (new_info.n_param != 3'd0) begin
                                st_d = ST_PARAM;
                            end else if (new_info.n_reply != 8'd0) begin
                                st_d = ST_REPLY;
                            end else begin
                                evt_done      = 1'b1;
                                evt_inreq_clr = new_info.clears_inreq;
                            end
                        end else begin
                            evt_bad = 1'b1;
                        end
                    end
                end
                ST_PARAM: begin
                    if (cmd_wr) begin
                        st_d       = ST_LATCH;
                        cnt_d      = BUSY_LOAD;
                        par_left_d = par_left_q - 1'b1;
                        if (cur_info.reply_from_param) rep_len_d = cmd_byte;
                    end
                end
                ST_LATCH: begin
                    if (cnt_q != '0) begin
                        cnt_d = cnt_q - 1'b1;
                    end else if (par_left_q != 3'd0) begin
                        st_d = ST_PARAM;
                    end else if (rep_len_q != 8'd0) begin
                        st_d = ST_REPLY;
                    end else begin
                        st_d          = ST_IDLE;
                        evt_done      = 1'b1;
                        evt_inreq_clr = cur_info.clears_inreq;
                    end
                end
                ST_FETCH: begin
                    st_d = ST_REPLY;
                end
                ST_REPLY: begin
                    if (cmd_wr && cmd_byte == OP_MBX_START) mbx_d = 1'b1;
                    if (data_rd) begin
                        if (idx_q == rep_len_q - 8'd1) begin
                            st_d          = ST_IDLE;
                            evt_done      = 1'b1;
                            evt_inreq_clr = cur_info.clears_inreq;
                        end else begin
                            idx_d = idx_q + 8'd1;
                            st_d  = ST_FETCH;
                        end
                    end
                end
                default: st_d = ST_IDLE;
            endcase
        end
    end

    // output process
    always_comb begin
        st         = st_q;
        op         = op_q;
        rep_idx    = idx_q;
        mbox_start = mbx_q;
    end

    // R7: a write landing in the busy window leaves the parameter bookkeeping alone
    a_r7_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_LATCH && cmd_wr && !hard_rst && !soft_rst)
        |=> (par_left_q == $past(par_left_q) && rep_len_q == $past(rep_len_q)));

    // R9: a data-in read always takes the byte away
    a_r9_read_clears_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_REPLY && data_rd && !hard_rst && !soft_rst) |=> (st_q != ST_REPLY));

    // R11: no mailbox strobe during the diagnostic period
    a_r11_no_start_in_diag: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DIAG && cmd_wr) |=> !mbx_q);
endmodule

// File: rtl/hba_event_flags.sv
module hba_event_flags (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr_int,
    input  logic       set_scsi,
    input  logic       any_reset,
    input  logic       evt_done,
    input  logic       evt_bad,
    input  logic       evt_inreq_clr,
    output logic [7:0] int_byte,
    output logic       cmd_invalid,
    output logic       init_req
);
    logic cmdc_q, scsi_q, cmdinv_q, inreq_q;
    logic wipe;

    assign wipe = clr_int | any_reset;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmdc_q   <= 1'b0;
            scsi_q   <= 1'b0;
            cmdinv_q <= 1'b0;
            inreq_q  <= 1'b1;
        end else begin
            cmdc_q   <= (evt_done | evt_bad) ? 1'b1 : (wipe ? 1'b0 : cmdc_q);
            scsi_q   <= set_scsi ? 1'b1 : (wipe ? 1'b0 : scsi_q);
            cmdinv_q <= evt_bad ? 1'b1 : (wipe ? 1'b0 : cmdinv_q);
            inreq_q  <= any_reset ? 1'b1 : (evt_inreq_clr ? 1'b0 : inreq_q);
        end
    end

    assign int_byte    = {(cmdc_q | scsi_q), 3'b000, scsi_q, cmdc_q, 2'b00};
    assign cmd_invalid = cmdinv_q;
    assign init_req    = inreq_q;

    // R12: an invalid command always completes
    a_r12_invalid_completes: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmdinv_q) |-> cmdc_q);

    // R4: a clear with no competing event leaves every flag low
    a_r4_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_int && !set_scsi && !evt_done && !evt_bad) |=> (!cmdc_q && !scsi_q && !cmdinv_q));

    // R13: every reset raises initialisation required
    a_r13_reset_sets_inreq: assert property (@(posedge clk) disable iff (!rst_n)
        any_reset |=> inreq_q);
endmodule

// File: rtl/hba_cmd_regs.sv
module hba_cmd_regs
    import hba_regs_pkg::*;
#(
    parameter int DIAG_CYCLES = 16,
    parameter int BUSY_CYCLES = 2,
    parameter int ADAPTER_ID  = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [1:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       mbox_start
);
    logic       ctl_wr, cmd_wr, data_rd;
    logic       hard_rst, soft_rst, clr_int, set_scsi;
    seq_state_t st;
    logic [7:0] op, rep_idx, reply_byte, int_byte, status_byte;
    logic       evt_done, evt_bad, evt_inreq_clr, cmd_invalid, init_req;
    logic       unused_ctl;

    assign ctl_wr   = bus_wr && bus_addr == 2'd0;
    assign cmd_wr   = bus_wr && bus_addr == 2'd1;
    assign data_rd  = bus_rd && bus_addr == 2'd1;
    assign hard_rst = ctl_wr && bus_wdata[CTL_HARD];
    assign soft_rst = ctl_wr && bus_wdata[CTL_SOFT];
    assign clr_int  = ctl_wr && bus_wdata[CTL_INTCLR];
    assign set_scsi = ctl_wr && bus_wdata[CTL_SCSI];
    assign unused_ctl = ^bus_wdata[3:0];

    hba_cmd_seq #(
        .DIAG_CYCLES (DIAG_CYCLES),
        .BUSY_CYCLES (BUSY_CYCLES)
    ) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .hard_rst      (hard_rst),
        .soft_rst      (soft_rst),
        .cmd_wr        (cmd_wr),
        .cmd_byte      (bus_wdata),
        .data_rd       (data_rd),
        .st            (st),
        .op            (op),
        .rep_idx       (rep_idx),
        .mbox_start    (mbox_start),
        .evt_done      (evt_done),
        .evt_bad       (evt_bad),
        .evt_inreq_clr (evt_inreq_clr)
    );

    hba_event_flags u_flags (
        .clk           (clk),
        .rst_n         (rst_n),
        .clr_int       (clr_int),
        .set_scsi      (set_scsi),
        .any_reset     (hard_rst | soft_rst),
        .evt_done      (evt_done),
        .evt_bad       (evt_bad),
        .evt_inreq_clr (evt_inreq_clr),
        .int_byte      (int_byte),
        .cmd_invalid   (cmd_invalid),
        .init_req      (init_req)
    );

    hba_reply_gen #(
        .ADAPTER_ID (ADAPTER_ID)
    ) u_reply (
        .op         (op),
        .idx        (rep_idx),
        .reply_byte (reply_byte)
    );

    assign status_byte = {
        (st == ST_DIAG),
        1'b0,
        init_req,
        (st == ST_IDLE),
        (st == ST_LATCH),
        (st == ST_REPLY),
        1'b0,
        cmd_invalid
    };

    always_comb begin
        unique case (bus_addr)
            2'd0:    bus_rdata = status_byte;
            2'd1:    bus_rdata = reply_byte;
            2'd2:    bus_rdata = int_byte;
            default: bus_rdata = 8'h00;
        endcase
    end

    // R11: the mailbox strobe never coincides with an interrupt change
    a_r11_start_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        mbox_start |-> $stable(int_byte));

    // R8: the cycle an opcode of the table is taken, ready goes low next
    a_r8_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && cmd_wr && !ctl_wr && op_lookup(bus_wdata).known
         && (op_lookup(bus_wdata).n_param != 3'd0 || op_lookup(bus_wdata).n_reply != 8'd0))
        |=> (st != ST_IDLE));
endmodule

// File: tb/tb_hba_cmd_regs.sv
module tb_hba_cmd_regs;
    localparam int DIAG = 5;
    localparam int BUSY = 3;
    localparam int AID  = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       mbox_start;

    int checks = 0, errors = 0;
    bit finished = 0;
    bit exp_inreq = 1;

    hba_cmd_regs #(.DIAG_CYCLES(DIAG), .BUSY_CYCLES(BUSY), .ADAPTER_ID(AID)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .mbox_start(mbox_start));

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic acc(input bit w, input bit r, input logic [1:0] a,
                       input logic [7:0] d, output logic [7:0] v);
        bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        logic [7:0] v;
        acc(1'b1, 1'b0, a, d, v);
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        acc(1'b0, 1'b1, a, 8'h00, v);
    endtask

    function automatic logic [7:0] idle_st();
        return exp_inreq ? 8'h30 : 8'h10;
    endfunction

    function automatic logic [7:0] wait_st();
        return exp_inreq ? 8'h20 : 8'h00;
    endfunction

    function automatic int n_par(input logic [7:0] op);
        case (op)
            8'h01: return 4;
            8'h81: return 5;
            8'h96, 8'h8D: return 1;
            default: return 0;
        endcase
    endfunction

    function automatic bit is_known(input logic [7:0] op);
        return op == 8'h01 || op == 8'h81 || op == 8'h96 || op == 8'h8D ||
               op == 8'h04 || op == 8'h0B;
    endfunction

    function automatic logic [7:0] exp_byte(input logic [7:0] op, input int i);
        if (op == 8'h04) return 8'h40 + 8'(i);
        if (op == 8'h0B) return (i == 0) ? 8'h00 : (i == 1) ? 8'h20 : 8'(AID);
        return (i == 0) ? 8'h45 : 8'(i);
    endfunction

    // count consecutive diagnostic samples; returns the first non-diag status
    task automatic diag_count(output int n, output logic [7:0] v);
        n = 0;
        rd(2'd0, v);
        while (v == 8'hA0 && n < 50) begin
            n++;
            rd(2'd0, v);
        end
    endtask

    task automatic wait_dirrdy();
        logic [7:0] v;
        int k = 0;
        rd(2'd0, v);
        while (!v[2] && k < 20) begin
            k++;
            rd(2'd0, v);
        end
        chk("R9 data-in ready appears", v & 8'h04, 8'h04);
    endtask

    // run one full command with given reply-length parameter for 0x8D
    task automatic run_cmd(input logic [7:0] op, input logic [7:0] len_par, input bit stray);
        logic [7:0] v;
        int np, nr, n;
        np = n_par(op);
        nr = (op == 8'h04) ? 4 : (op == 8'h0B) ? 3 : (op == 8'h8D) ? int'(len_par) : 0;
        wr(2'd1, op);
        rd(2'd0, v);
        chk("R8 ready drops after opcode", v,
            wait_st() | ((np == 0 && nr > 0) ? 8'h04 : 8'h00));
        for (int j = 0; j < np; j++) begin
            wr(2'd1, (op == 8'h8D) ? len_par : 8'(j + 1));
            n = 0;
            if (stray) begin
                wr(2'd1, 8'h09);
                n++;
            end
            rd(2'd0, v);
            while (v[3] && n < 50) begin
                n++;
                rd(2'd0, v);
            end
            chk("R7 busy length", 8'(n), 8'(BUSY));
        end
        if (nr == 0 && np > 0) begin
            if (op == 8'h01 || op == 8'h81) exp_inreq = 0;
            chk("R8 ready after last parameter", v, idle_st());
        end
        for (int i = 0; i < nr; i++) begin
            wait_dirrdy();
            rd(2'd1, v);
            chk("R10 reply byte", v, exp_byte(op, i));
            if (i < nr - 1) begin
                rd(2'd0, v);
                chk("R9 ready cleared by read", v & 8'h04, 8'h00);
            end
        end
        rd(2'd0, v);
        chk("R8 idle after command", v, idle_st());
        rd(2'd2, v);
        chk("R3 completion interrupt", v, 8'h84);
        wr(2'd0, 8'h20);
        rd(2'd2, v);
        chk("R4 interrupt cleared", v, 8'h00);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R2: reset state and diagnostic period
        diag_count(n, v);
        chk("R2 diag cycles after rst_n", 8'(n), 8'(DIAG));
        chk("R2 settled status", v, 8'h30);
        rd(2'd2, v);
        chk("R2 interrupt after reset", v, 8'h00);

        // R1: offset 3 reads zero, writes to 2/3 ignored
        rd(2'd3, v);
        chk("R1 offset 3 reads zero", v, 8'h00);
        wr(2'd2, 8'hFF);
        wr(2'd3, 8'hFF);
        rd(2'd0, v);
        chk("R1 status after stray writes", v, 8'h30);
        rd(2'd2, v);
        chk("R1 interrupt after stray writes", v, 8'h00);

        // R4/R3: SCSI reset state bit
        wr(2'd0, 8'h10);
        rd(2'd2, v);
        chk("R4 scsi reset state set", v, 8'h88);
        wr(2'd0, 8'h30);
        rd(2'd2, v);
        chk("R4 set wins over clear", v, 8'h88);
        wr(2'd0, 8'h20);
        rd(2'd2, v);
        chk("R4 clear", v, 8'h00);

        // R11: mailbox start in idle
        wr(2'd1, 8'h02);
        chk("R11 strobe in idle", 8'(mbox_start), 8'h01);
        rd(2'd0, v);
        chk("R11 status unchanged", v, 8'h30);
        chk("R11 strobe one cycle", 8'(mbox_start), 8'h00);
        rd(2'd2, v);
        chk("R11 no completion", v, 8'h00);

        // R6/R12: sweep every opcode
        for (int op = 0; op < 256; op++) begin
            if (op == 2) continue;
            if (is_known(8'(op))) begin
                run_cmd(8'(op), 8'd3, 1'b0);
            end else begin
                wr(2'd1, 8'(op));
                rd(2'd0, v);
                chk("R12 invalid status", v, idle_st() | 8'h01);
                rd(2'd2, v);
                chk("R12 invalid interrupt", v, 8'h84);
                wr(2'd0, 8'h20);
                rd(2'd0, v);
                chk("R4 clear removes invalid", v, idle_st());
            end
        end

        // R6: reply length from parameter, several values; R7 stray write in busy
        run_cmd(8'h8D, 8'd0, 1'b0);
        run_cmd(8'h8D, 8'd1, 1'b0);
        run_cmd(8'h8D, 8'd7, 1'b0);
        run_cmd(8'h8D, 8'd2, 1'b1);

        // R14 and R11 during reply
        wr(2'd1, 8'h04);
        rd(2'd1, v);
        chk("R10 first byte", v, 8'h40);
        wr(2'd1, 8'h0B);
        wait_dirrdy();
        wr(2'd1, 8'h02);
        chk("R11 strobe during reply", 8'(mbox_start), 8'h01);
        rd(2'd1, v);
        chk("R14 reply undisturbed", v, 8'h41);
        // R5: soft reset mid-reply
        wr(2'd0, 8'h40);
        exp_inreq = 1;
        rd(2'd0, v);
        chk("R5 soft reset status", v, 8'h30);
        rd(2'd2, v);
        chk("R5 soft reset interrupts", v, 8'h00);

        // R13: 0x81 clears init required, hard reset restores it
        run_cmd(8'h81, 8'd0, 1'b0);
        rd(2'd0, v);
        chk("R13 init required cleared", v, 8'h10);
        wr(2'd0, 8'h90);
        exp_inreq = 1;
        wr(2'd1, 8'h04);
        wr(2'd1, 8'h02);
        chk("R11 ignored in diag", 8'(mbox_start), 8'h00);
        diag_count(n, v);
        chk("R2 diag after control hard reset", 8'(n), 8'(DIAG - 2));
        chk("R14 write in diag ignored", v, 8'h30);
        rd(2'd2, v);
        chk("R4 scsi bit with hard reset", v, 8'h88);
        wr(2'd0, 8'h20);
        run_cmd(8'h0B, 8'd0, 1'b0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule